// File: doc/BRIEF.md
# Power-Aware Interrupt Target Selector

This block decides which processor core receives a redirectable interrupt. For each core it takes an eligibility bit, a 3-bit idle-depth code and a turbo-request flag. A single bias input chooses between two policies. The power policy keeps sleeping cores asleep: it prefers the core that is already most awake and avoids a core asking for turbo. The performance policy leaves busy cores alone: it prefers the most deeply idle core, which it wakes, and favours a core asking for turbo.

A request strobe starts one decision. One cycle later the block presents a one-hot target vector with a valid pulse. With the target it gives a flag telling whether the chosen core is currently asleep and so has to be woken. If no core is eligible, the block raises an error pulse in place of a target. Any remaining tie goes to the lowest-numbered core, so the outcome is fully deterministic. Delivering the interrupt and waking the core are left to surrounding logic.

Top module: `irq_target_sel`

## Requirements
- R1: The decision appears on the outputs exactly one clock cycle after the cycle in which `req_valid_i` is sampled high. In any cycle not following a request, `tgt_valid_o`, `wake_o` and `no_target_o` are low and `tgt_o` is zero.
- R2: When `tgt_valid_o` is high, `tgt_o` has exactly one bit set, and that bit is a core whose `elig_i` bit was set in the request cycle. Bit i of `tgt_o`, `elig_i` and `turbo_i` refers to core i.
- R3: The idle depth of core i is `cstate_i[3*i+2 : 3*i]`. Code 0 means active, and a larger code means a deeper sleep (7 is the deepest).
- R4: With `perf_mode_i` = 0 (power bias), the eligible core with the smallest idle-depth code is chosen.
- R5: Under power bias, among eligible cores that share the smallest code, a core with `turbo_i` = 0 is preferred over one with `turbo_i` = 1.
- R6: With `perf_mode_i` = 1 (performance bias), the eligible core with the largest idle-depth code is chosen.
- R7: Under performance bias, among eligible cores that share the largest code, a core with `turbo_i` = 1 is preferred over one with `turbo_i` = 0.
- R8: A tie that remains after R4 to R7 goes to the lowest-numbered core.
- R9: `wake_o` is high together with `tgt_valid_o` exactly when the chosen core's idle-depth code is nonzero.
- R10: A request with an all-zero `elig_i` produces a one-cycle `no_target_o` pulse in the following cycle, with `tgt_valid_o` and `wake_o` low and `tgt_o` zero.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request strobe, one decision per high cycle |
| perf_mode_i | input | 1 | Bias select: 0 power, 1 performance |
| elig_i | input | NUM_CORES | Cores allowed to take this interrupt |
| cstate_i | input | NUM_CORES*3 | Packed per-core idle-depth codes |
| turbo_i | input | NUM_CORES | Per-core turbo request flags |
| tgt_o | output | NUM_CORES | One-hot chosen core |
| tgt_valid_o | output | 1 | Target valid pulse |
| wake_o | output | 1 | Chosen core is asleep and will be woken |
| no_target_o | output | 1 | Error pulse: no core was eligible |

## Verification
On every cycle the assertions check the structural properties. A valid target is one-hot and was eligible. Outputs stay quiet after a cycle without a request. An eligible request always produces a target, and an empty mask always produces the error pulse. The flag that marks a sleeping target always agrees with the selected core's depth code. Which core wins is a matter of policy, and only the bench's scenarios can show it. Those scenarios pit an active core against a deeply idle one under each bias, build ties broken by turbo and by core index, and hide a better-ranked core behind the eligibility mask.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic {
    BIAS_POWER = 1'b0,
    BIAS_PERF  = 1'b1
  } bias_e;

  localparam int unsigned CST_W_DEF = 3;
endpackage

// File: rtl/irq_rank_key.sv
// Per-core rank key: larger key means more preferred under the chosen bias.
module irq_rank_key
  import irq_sel_pkg::*;
#(
  parameter int unsigned CST_W = 3,
  localparam int unsigned KEY_W = CST_W + 1
) (
  input  logic [CST_W-1:0] cstate_i,
  input  logic             turbo_i,
  input  bias_e            bias_i,
  output logic [KEY_W-1:0] key_o
);
  always_comb begin
    if (bias_i == BIAS_PERF) key_o = {cstate_i, turbo_i};
    else                     key_o = {~cstate_i, ~turbo_i};
  end
endmodule

// File: rtl/irq_pick_max.sv
// Linear scan for the largest key among eligible cores; strict compare keeps lowest index on ties.
module irq_pick_max #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned KEY_W     = 4,
  localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES*KEY_W-1:0] key_i,
  input  logic [NUM_CORES-1:0]       elig_i,
  output logic [NUM_CORES-1:0]       onehot_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic                       found_o
);
  logic [KEY_W-1:0] best;

  always_comb begin
    best    = '0;
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < int'(NUM_CORES); i++) begin
      if (elig_i[i] && (!found_o || key_i[i*KEY_W +: KEY_W] > best)) begin
        best    = key_i[i*KEY_W +: KEY_W];
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end

  always_comb begin
    onehot_o = '0;
    if (found_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CST_W     = 3,
  localparam int unsigned KEY_W    = CST_W + 1,
  localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       perf_mode_i,
  input  logic [NUM_CORES-1:0]       elig_i,
  input  logic [NUM_CORES*CST_W-1:0] cstate_i,
  input  logic [NUM_CORES-1:0]       turbo_i,
  output logic [NUM_CORES-1:0]       tgt_o,
  output logic                       tgt_valid_o,
  output logic                       wake_o,
  output logic                       no_target_o
);
  bias_e                      bias;
  logic [NUM_CORES*KEY_W-1:0] keys;
  logic [NUM_CORES-1:0]       pick_oh;
  logic [IDX_W-1:0]           pick_idx;
  logic                       pick_found;
  logic [CST_W-1:0]           pick_cst;

  assign bias = bias_e'(perf_mode_i);

  for (genvar g = 0; g < int'(NUM_CORES); g++) begin : g_key
    irq_rank_key #(.CST_W(CST_W)) u_key (
      .cstate_i (cstate_i[g*CST_W +: CST_W]),
      .turbo_i  (turbo_i[g]),
      .bias_i   (bias),
      .key_o    (keys[g*KEY_W +: KEY_W])
    );
  end

  irq_pick_max #(.NUM_CORES(NUM_CORES), .KEY_W(KEY_W)) u_pick (
    .key_i    (keys),
    .elig_i   (elig_i),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx),
    .found_o  (pick_found)
  );

  assign pick_cst = cstate_i[pick_idx*CST_W +: CST_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_o       <= '0;
      tgt_valid_o <= 1'b0;
      wake_o      <= 1'b0;
      no_target_o <= 1'b0;
    end else if (req_valid_i) begin
      tgt_o       <= pick_oh;
      tgt_valid_o <= pick_found;
      wake_o      <= pick_found && (pick_cst != '0);
      no_target_o <= !pick_found;
    end else begin
      tgt_o       <= '0;
      tgt_valid_o <= 1'b0;
      wake_o      <= 1'b0;
      no_target_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_target_sel_chk.sv
module irq_target_sel_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CST_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic [NUM_CORES-1:0]       elig_i,
  input logic [NUM_CORES*CST_W-1:0] cstate_i,
  input logic [NUM_CORES-1:0]       tgt_o,
  input logic                       tgt_valid_o,
  input logic                       wake_o,
  input logic                       no_target_o
);
  logic [CST_W-1:0] tgt_cst;
  logic [CST_W-1:0] cst_q [NUM_CORES];

  for (genvar g = 0; g < int'(NUM_CORES); g++) begin : g_cq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cst_q[g] <= '0;
      else         cst_q[g] <= cstate_i[g*CST_W +: CST_W];
    end
  end

  always_comb begin
    tgt_cst = '0;
    for (int i = 0; i < int'(NUM_CORES); i++)
      if (tgt_o[i]) tgt_cst = cst_q[i];
  end

  // R1
  quiet_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!tgt_valid_o && !wake_o && !no_target_o && tgt_o == '0));

  // R1
  eligible_gives_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && elig_i != '0) |=> tgt_valid_o);

  // R2
  target_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> ($countones(tgt_o) == 1));

  // R2
  target_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ((tgt_o & ~$past(elig_i)) == '0));

  // R9
  wake_matches_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> (wake_o == (tgt_cst != '0)));

  // R9
  wake_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> tgt_valid_o);

  // R10
  empty_mask_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && elig_i == '0) |=> (no_target_o && !tgt_valid_o && tgt_o == '0));
endmodule

bind irq_target_sel irq_target_sel_chk #(.NUM_CORES(NUM_CORES), .CST_W(CST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .elig_i      (elig_i),
  .cstate_i    (cstate_i),
  .tgt_o       (tgt_o),
  .tgt_valid_o (tgt_valid_o),
  .wake_o      (wake_o),
  .no_target_o (no_target_o)
);

// File: tb/irq_target_sel_bench.sv
module irq_target_sel_bench;
  localparam int N     = 4;
  localparam int CW    = 3;
  localparam time TCLK = 20ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          perf_mode_i = 1'b0;
  logic [N-1:0]  elig_i = '0;
  logic [N*CW-1:0] cstate_i = '0;
  logic [N-1:0]  turbo_i = '0;
  logic [N-1:0]  tgt_o;
  logic          tgt_valid_o, wake_o, no_target_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [N-1:0] tgt;
    logic         vld;
    logic         wake;
    logic         err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  pend = 1'b0;

  always #(TCLK/2) clk_i = ~clk_i;

  irq_target_sel #(.NUM_CORES(N), .CST_W(CW)) u_irq_target_sel (.*);

  always @(posedge clk_i) pend <= req_valid_i;

  function automatic exp_t model(input logic [N-1:0] el, input logic [N*CW-1:0] cs,
                                 input logic [N-1:0] tb, input logic perf);
    exp_t e;
    int best;
    best = -1;
    for (int i = 0; i < N; i++) begin
      if (el[i]) begin
        if (best < 0) best = i;
        else begin
          int ci, cb;
          ci = int'(cs[i*CW +: CW]);
          cb = int'(cs[best*CW +: CW]);
          if (perf) begin
            if (ci > cb || (ci == cb && tb[i] && !tb[best])) best = i;
          end else begin
            if (ci < cb || (ci == cb && !tb[i] && tb[best])) best = i;
          end
        end
      end
    end
    e = '0;
    if (best < 0) e.err = 1'b1;
    else begin
      e.tgt[best] = 1'b1;
      e.vld = 1'b1;
      e.wake = (cs[best*CW +: CW] != '0);
    end
    return e;
  endfunction

  function automatic logic [N*CW-1:0] pk(input int c0, input int c1, input int c2, input int c3);
    return {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
  endfunction

  // Drives one request cycle (from a negedge) and queues the expected result.
  task automatic drive(input string tag, input logic [N-1:0] el, input logic [N*CW-1:0] cs,
                       input logic [N-1:0] tb, input logic perf);
    elig_i = el; cstate_i = cs; turbo_i = tb; perf_mode_i = perf;
    req_valid_i = 1'b1;
    exp_q.push_back(model(el, cs, tb, perf));
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check_idle(input string tag);
    n_run++;
    if (tgt_valid_o !== 1'b0 || wake_o !== 1'b0 || no_target_o !== 1'b0 || tgt_o !== '0) begin
      n_fail++;
      $display("FAIL %s idle: got tgt=%b v=%b w=%b e=%b exp all zero",
               tag, tgt_o, tgt_valid_o, wake_o, no_target_o);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (pend && exp_q.size() != 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (tgt_o !== e.tgt || tgt_valid_o !== e.vld || wake_o !== e.wake || no_target_o !== e.err) begin
          n_fail++;
          $display("FAIL %s: got tgt=%b v=%b w=%b e=%b exp tgt=%b v=%b w=%b e=%b",
                   t, tgt_o, tgt_valid_o, wake_o, no_target_o, e.tgt, e.vld, e.wake, e.err);
        end
      end
    end
  end

  initial begin
    #(TCLK * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    check_idle("R11");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1");

    // R4: core1 active, core2 in depth 6, power bias -> core1, no wake
    drive("R4", 4'b0110, pk(0, 0, 6, 0), 4'b0000, 1'b0);
    drain();
    check_idle("R1 after R4");
    // R6 / R9: same state, perf bias -> core2, wake
    drive("R6", 4'b0110, pk(0, 0, 6, 0), 4'b0000, 1'b1);
    // R5: tie at depth 2, core0 turbo, core3 not -> core3
    drive("R5", 4'b1001, pk(2, 0, 0, 2), 4'b0001, 1'b0);
    // R7: tie at depth 3, core2 turbo, core1 not -> core2
    drive("R7", 4'b0110, pk(0, 3, 3, 0), 4'b0100, 1'b1);
    // R8: identical cores
    drive("R8", 4'b1111, pk(1, 1, 1, 1), 4'b0000, 1'b0);
    drive("R8", 4'b1110, pk(4, 4, 4, 4), 4'b1111, 1'b1);
    // R3: deepest code 7 beats 6 under perf bias
    drive("R3", 4'b1010, pk(0, 6, 0, 7), 4'b0000, 1'b1);
    // R2: ineligible core0 is active but must be skipped
    drive("R2", 4'b1100, pk(0, 5, 3, 2), 4'b0000, 1'b0);
    // R9: all eligible cores asleep under power bias -> wake shallowest
    drive("R9", 4'b1111, pk(5, 1, 3, 2), 4'b0000, 1'b0);
    // R10: empty mask
    drive("R10", 4'b0000, pk(0, 0, 0, 0), 4'b1111, 1'b0);
    drain();
    check_idle("R10 single pulse");

    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive("R2 mix", lfsr[3:0], {lfsr[11:0]} ^ {lfsr[15:4]}, lfsr[7:4], lfsr[8]);
    end
    drain();
    check_idle("R1 end");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule